// File: doc/BRIEF.md
# Keyed Region Reset Controller

This block gives the host a single write-only path for resetting parts of the chip. The register space is divided into eight regions of 256 bytes each. A write to the reset register carries three fields: an eight-bit region mask, a key byte and a sixteen-bit special code. Region n is reset when bit n of the mask is set. That reset also covers the logic the region controls. Each selected region gets a reset pulse of fixed length, and the pulse is released without further action by the host.

The key byte guards every effect of the reset register. A write with the wrong key does nothing. Region resets are also blocked whenever byte 1 of the main control register is non-zero. That register is held inside this block and is written through the same bus. Two special codes are recognised. One code pulses the coprocessor reset. The other code switches on bus encryption, and encryption then stays on until the next system reset. The control register sits in region 2, so resetting that region returns the control register to its initial value.

Top module: `blk_reset_ctl`

## Requirements
- R1: During and right after system reset, every region reset, the coprocessor reset and the encryption enable are low, and the control register reads 0.
- R2: A write to the control address (0x208) loads all 32 bits of data into the control register at the next clock edge. Writes to any other address leave the control register unchanged.
- R3: A write to the reset address (0x210) with key byte 0xB2 in bits 15:8 and a zero control register byte 1 (bits 15:8) asserts the region reset for each bit set in mask bits 7:0. Each such reset goes high in the cycle after the write and stays high for exactly 4 cycles.
- R4: A reset-register write whose key byte is not 0xB2 changes no output: no region reset, no coprocessor reset and no encryption change.
- R5: While control register bits 15:8 are non-zero, the mask is ignored even when the key is correct.
- R6: A correctly keyed write with code 0xC258 in bits 31:16 pulses the coprocessor reset high for 4 cycles, starting the cycle after the write. The control register gating does not block this.
- R7: A correctly keyed write with code 0xC25A in bits 31:16 sets the encryption enable. It then stays set until the system reset.
- R8: Special codes other than 0xC258 and 0xC25A have no effect.
- R9: Selecting a region whose pulse is still running restarts that pulse at the full 4 cycles.
- R10: Selecting region 2 clears the control register to 0. The register stays at 0, and ignores writes, for as long as the region 2 pulse lasts.
- R11: A single write that carries both a mask and a special code applies both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 12 | Bus byte address |
| wr_data | input | 32 | Bus write data |
| blk_rst | output | 8 | Per-region reset pulses |
| cop_rst | output | 1 | Coprocessor reset pulse |
| crypt_en | output | 1 | Bus encryption enable, sticky |
| ctrl_q | output | 32 | Main control register contents |

## Verification
A single reset-register write can start region pulses and a special action in the same cycle. The bench provokes this on purpose by writing a mask together with the coprocessor code, and it checks that both pulses rise on the same edge. A second collision happens when a region 2 reset clears the control register that gates the mask, while host writes to that register arrive during the pulse. The bench judges that case against its own model, which requires the control register to stay at 0 until the pulse ends. Random writes mix keys, codes and control values so that both collisions recur many times.

// File: rtl/blk_reset_ctl.sv
module blk_reset_ctl #(
  parameter int ADDR_W = 12,
  parameter logic [11:0] RST_ADDR = 12'h210,
  parameter logic [11:0] CTRL_ADDR = 12'h208,
  parameter int NBLK = 8,
  parameter logic [7:0] KEY = 8'hB2,
  parameter logic [15:0] COP_CODE = 16'hC258,
  parameter logic [15:0] CRYPT_CODE = 16'hC25A,
  parameter int PULSE_LEN = 4,
  parameter int SELF_BLK = 2,
  parameter logic [31:0] CTRL_INIT = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [NBLK-1:0]   blk_rst,
  output logic              cop_rst,
  output logic              crypt_en,
  output logic [31:0]       ctrl_q
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LEN = CW'(PULSE_LEN);

  logic rst_hit, key_ok, gate_open, cop_trig, crypt_set;
  logic [NBLK-1:0] trig;

  assign rst_hit   = wr_en && (wr_addr == RST_ADDR[ADDR_W-1:0]);
  assign key_ok    = rst_hit && (wr_data[15:8] == KEY);
  assign gate_open = (ctrl_q[15:8] == 8'h00);
  assign trig      = (key_ok && gate_open) ? wr_data[NBLK-1:0] : '0;
  assign cop_trig  = key_ok && (wr_data[31:16] == COP_CODE);
  assign crypt_set = key_ok && (wr_data[31:16] == CRYPT_CODE);

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       cnt <= '0;
      else if (trig[i]) cnt <= LEN;
      else if (cnt != 0) cnt <= cnt - 1'b1;
    assign blk_rst[i] = (cnt != 0);
  end

  logic [CW-1:0] cop_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cop_cnt <= '0;
    else if (cop_trig)     cop_cnt <= LEN;
    else if (cop_cnt != 0) cop_cnt <= cop_cnt - 1'b1;
  assign cop_rst = (cop_cnt != 0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         crypt_en <= 1'b0;
    else if (crypt_set) crypt_en <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      ctrl_q <= CTRL_INIT;
    else if (trig[SELF_BLK] || blk_rst[SELF_BLK])
      ctrl_q <= CTRL_INIT;
    else if (wr_en && (wr_addr == CTRL_ADDR[ADDR_W-1:0]))
      ctrl_q <= wr_data;
endmodule

module blk_reset_ctl_chk #(
  parameter int ADDR_W = 12,
  parameter logic [11:0] RST_ADDR = 12'h210,
  parameter int NBLK = 8,
  parameter logic [7:0] KEY = 8'hB2,
  parameter logic [15:0] COP_CODE = 16'hC258,
  parameter logic [15:0] CRYPT_CODE = 16'hC25A,
  parameter int SELF_BLK = 2,
  parameter logic [31:0] CTRL_INIT = 32'h0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [NBLK-1:0]   blk_rst,
  input logic              cop_rst,
  input logic              crypt_en,
  input logic [31:0]       ctrl_q
);
  logic at_rst;
  assign at_rst = wr_en && (wr_addr == RST_ADDR[ADDR_W-1:0]);

  // R3
  rise_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((blk_rst & ~$past(blk_rst)) != '0) |-> $past(at_rst && wr_data[15:8] == KEY && ctrl_q[15:8] == 8'h00));

  // R4
  bad_key_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_rst && wr_data[15:8] != KEY && blk_rst == '0 && !cop_rst) |=> (blk_rst == '0 && !cop_rst && $stable(crypt_en)));

  // R5
  gated_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_rst && ctrl_q[15:8] != 8'h00 && blk_rst == '0) |=> (blk_rst == '0));

  // R6
  cop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_rst && wr_data[15:8] == KEY && wr_data[31:16] == COP_CODE) |=> cop_rst);

  // R7
  crypt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_rst && wr_data[15:8] == KEY && wr_data[31:16] == CRYPT_CODE) |=> crypt_en);

  // R7
  crypt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(crypt_en));

  // R10
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_rst[SELF_BLK] |-> (ctrl_q == CTRL_INIT));
endmodule

bind blk_reset_ctl blk_reset_ctl_chk #(
  .ADDR_W(ADDR_W), .RST_ADDR(RST_ADDR), .NBLK(NBLK), .KEY(KEY),
  .COP_CODE(COP_CODE), .CRYPT_CODE(CRYPT_CODE), .SELF_BLK(SELF_BLK), .CTRL_INIT(CTRL_INIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .blk_rst(blk_rst), .cop_rst(cop_rst), .crypt_en(crypt_en), .ctrl_q(ctrl_q)
);

// File: tb/blk_reset_ctl_test.sv
module blk_reset_ctl_test;
  localparam logic [11:0] A_RST  = 12'h210;
  localparam logic [11:0] A_CTRL = 12'h208;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0] blk_rst;
  logic cop_rst, crypt_en;
  logic [31:0] ctrl_q;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  int m_cnt [8];
  int m_cop = 0;
  bit m_crypt = 0;
  logic [31:0] m_ctrl = '0;

  always #4 clk = ~clk;

  blk_reset_ctl uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .blk_rst(blk_rst), .cop_rst(cop_rst), .crypt_en(crypt_en), .ctrl_q(ctrl_q));

  function automatic logic [7:0] exp_blk();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = (m_cnt[i] != 0);
    return v;
  endfunction

  task automatic model(input bit we, input logic [11:0] a, input logic [31:0] d);
    bit kok = we && a == A_RST && d[15:8] == 8'hB2;
    logic [7:0] tr = (kok && m_ctrl[15:8] == 8'h00) ? d[7:0] : 8'h00;
    if (tr[2] || m_cnt[2] != 0) m_ctrl = 32'h0;
    else if (we && a == A_CTRL) m_ctrl = d;
    for (int i = 0; i < 8; i++) m_cnt[i] = tr[i] ? 4 : (m_cnt[i] != 0 ? m_cnt[i] - 1 : 0);
    m_cop = (kok && d[31:16] == 16'hC258) ? 4 : (m_cop != 0 ? m_cop - 1 : 0);
    if (kok && d[31:16] == 16'hC25A) m_crypt = 1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(input string tag);
    chk(tag, {24'h0, blk_rst}, {24'h0, exp_blk()}, "blk_rst");
    chk(tag, {31'h0, cop_rst}, {31'h0, m_cop != 0}, "cop_rst");
    chk(tag, {31'h0, crypt_en}, {31'h0, m_crypt}, "crypt_en");
    chk(tag, ctrl_q, m_ctrl, "ctrl_q");
  endtask

  task automatic step(input bit we, input logic [11:0] a, input logic [31:0] d, input string tag);
    wr_en = we; wr_addr = a; wr_data = d;
    model(we, a, d);
    @(posedge clk);
    @(negedge clk);
    cmp_all(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 12'h0, 32'h0, tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    for (int i = 0; i < 8; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    cmp_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all("R1");

    step(1, A_CTRL, 32'hA5A5_00FF, "R2");
    step(1, 12'h20C, 32'h1111_1111, "R2");
    step(1, A_RST, 32'h0000_B201, "R3");
    idle(5, "R3");
    step(1, A_RST, 32'hC25A_B3FF, "R4");
    idle(2, "R4");
    step(1, A_CTRL, 32'h0000_0100, "R5");
    step(1, A_RST, 32'h0000_B2FF, "R5");
    step(1, A_RST, 32'hC258_B2FF, "R6");
    idle(5, "R6");
    step(1, A_RST, 32'hC259_B200, "R8");
    step(1, A_RST, 32'h0000_B200, "R8");
    step(1, A_RST, 32'hFFFF_B200, "R8");
    idle(2, "R8");
    step(1, A_RST, 32'hC25A_B200, "R7");
    step(1, A_RST, 32'h0000_B200, "R7");
    idle(2, "R7");
    step(1, A_CTRL, 32'h0, "R10");
    step(1, A_RST, 32'h0000_B204, "R10");
    step(1, A_CTRL, 32'h1234_5678, "R10");
    idle(2, "R10");
    step(1, A_CTRL, 32'h0000_0077, "R10");
    step(1, A_CTRL, 32'h0000_0055, "R10");
    step(1, A_RST, 32'h0000_B280, "R9");
    idle(2, "R9");
    step(1, A_RST, 32'h0000_B280, "R9");
    idle(5, "R9");
    step(1, A_RST, 32'hC258_B230, "R11");
    idle(5, "R11");

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] d;
      logic [11:0] a;
      int r;
      r = $urandom_range(0, 9);
      a = (r < 6) ? A_RST : (r < 8) ? A_CTRL : 12'($urandom_range(0, 4095));
      d = $urandom;
      if (a == A_CTRL && $urandom_range(0, 9) < 7) d[15:8] = 8'h00;
      if (a == A_RST) begin
        if ($urandom_range(0, 9) < 7) d[15:8] = 8'hB2;
        r = $urandom_range(0, 5);
        if (r == 0) d[31:16] = 16'hC258;
        else if (r == 1) d[31:16] = 16'hC25A;
        else if (r == 2) d[31:16] = 16'hC259;
      end
      step($urandom_range(0, 2) != 0, a, d, "R3/R6/R7/R10 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule